// File: doc/BRIEF.md
# USB Packet Field Phase Tracker

This block sits in the receive path of a passive USB bus monitor, after the bit-level front end. The front end handles line decoding and bit unstuffing and is outside this block. The block follows the packet byte by byte and reports which field is on the wire as a 4-bit phase code. It tells three packet kinds apart:

- token and start-of-frame packets, where the two bytes after the PID are split into their fields;
- data packets, whose payload bytes are passed on with a qualifier;
- handshake packets, which carry no fields.

The front end supplies four inputs:

- a one-cycle end-of-sync pulse;
- a byte strobe with the received byte;
- a two-bit packet-kind code decoded from the PID byte;
- a one-cycle end-of-packet pulse.

The block returns three things. The device address and endpoint of the last complete token are held across the data packet that follows, so that a recorder can tag payload with its destination. The frame number of the last complete start-of-frame packet is also held. Payload bytes come out delayed by two bytes. This keeps the two trailing CRC bytes of a data packet, which can only be identified once end-of-packet arrives, from ever being reported as payload.

Top module: `usb_phase_tracker`

## Requirements
- R1: The phase output uses these codes: idle 0000, PID 0001, first delay 0010, second delay 0011, low field 0100, high field 0101, CRC 0110, pre-data 0111, data 1000. No other code ever appears.
- R2: In idle, an end-of-sync pulse moves the phase to PID on the next cycle. An end-of-sync pulse in any other phase has no effect on the phase.
- R3: In PID, a byte strobe samples the packet kind (0 handshake, 1 token, 2 start-of-frame, 3 data). For a kind other than handshake, the phase then spends exactly one cycle in each delay state. It then enters low field for token and start-of-frame, and pre-data for data.
- R4: In a token, a byte in low field moves the phase to high field, and a byte in high field moves it to CRC. At end-of-packet in CRC, the address becomes bits 6:0 of the first field byte. At the same point, the endpoint becomes bits 2:0 of the second field byte, placed above bit 7 of the first field byte.
- R5: Address and endpoint keep their values through any later data, start-of-frame or handshake packet. They change only when another token completes.
- R6: In a data packet, the first two bytes are held while the phase stays in pre-data. The second of them moves the phase to data. Each byte strobe in data releases, on the next cycle, the byte received two strobes earlier, with the payload qualifier high for one cycle.
- R7: A handshake packet keeps the phase at PID after its PID byte, and the phase returns to idle at end-of-packet.
- R8: The frame number becomes {second field byte bits 2:0, first field byte} only at end-of-packet in CRC of a start-of-frame packet. At every other time it holds.
- R9: End-of-packet in any phase makes the phase idle on the next cycle. A byte strobed in the same cycle is dropped. Partial fields and the two held bytes are discarded without changing the address, endpoint or frame outputs.
- R10: After reset the phase is idle and the address, endpoint, frame, payload byte and qualifier are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_end_i | input | 1 | One-cycle pulse at end of sync pattern |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| pid_kind_i | input | 2 | Packet kind decoded from PID, sampled with the PID byte |
| eop_i | input | 1 | One-cycle end-of-packet pulse |
| phase_o | output | 4 | Current field phase code |
| addr_o | output | 7 | Address of the last complete token |
| endp_o | output | 4 | Endpoint of the last complete token |
| frame_o | output | 11 | Frame number of the last complete start-of-frame |
| payload_o | output | 8 | Released payload byte |
| payload_vld_o | output | 1 | Payload byte qualifier |

## Verification
The bench sends one packet of each kind and steps through the phase codes one strobe at a time. This separates the fixed two-cycle delay from the strobe-driven field phases. A four-byte data packet shows that payload is released in order while its two CRC bytes are held back. A data packet with no payload, which has only its CRC bytes, shows that nothing is released at all. A start-of-frame packet and a token cut short by end-of-packet are sent between two data packets. They show that the held address and endpoint survive unrelated and truncated packets, and that the frame number moves only when a full start-of-frame packet ends.

// File: rtl/usbpt_pkg.sv
package usbpt_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int EP_W    = 4;
    localparam int FRAME_W = 11;
    localparam int HI_W    = FRAME_W - BYTE_W;

    typedef enum logic [3:0] {
        PH_IDLE   = 4'h0,
        PH_PID    = 4'h1,
        PH_DLY1   = 4'h2,
        PH_DLY2   = 4'h3,
        PH_FLD_LO = 4'h4,
        PH_FLD_HI = 4'h5,
        PH_CRC    = 4'h6,
        PH_PRE    = 4'h7,
        PH_DATA   = 4'h8
    } phase_e;

    typedef enum logic [1:0] {
        PK_HSK = 2'd0,
        PK_TOK = 2'd1,
        PK_SOF = 2'd2,
        PK_DAT = 2'd3
    } pkind_e;
endpackage

// File: rtl/usbpt_seq.sv
module usbpt_seq
    import usbpt_pkg::*;
#(
    parameter int TAIL = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sync_end_i,
    input  logic   byte_vld_i,
    input  pkind_e kind_i,
    input  logic   eop_i,
    output phase_e phase_o,
    output pkind_e kind_o
);
    localparam int CNT_W = $clog2(TAIL + 1);

    typedef struct packed {
        phase_e            ph;
        pkind_e            kind;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (eop_i) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else begin
            case (st_q.ph)
                PH_IDLE:   if (sync_end_i) st_d.ph = PH_PID;
                PH_PID: begin
                    if (byte_vld_i) begin
                        st_d.kind = kind_i;
                        if (kind_i != PK_HSK) st_d.ph = PH_DLY1;
                    end
                end
                PH_DLY1:   st_d.ph = PH_DLY2;
                PH_DLY2: begin
                    st_d.ph  = (st_q.kind == PK_DAT) ? PH_PRE : PH_FLD_LO;
                    st_d.cnt = '0;
                end
                PH_FLD_LO: if (byte_vld_i) st_d.ph = PH_FLD_HI;
                PH_FLD_HI: if (byte_vld_i) st_d.ph = PH_CRC;
                PH_CRC:    st_d.ph = PH_CRC;
                PH_PRE: begin
                    if (byte_vld_i) begin
                        if (st_q.cnt == CNT_W'(TAIL - 1)) begin
                            st_d.ph  = PH_DATA;
                            st_d.cnt = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_DATA:   st_d.ph = PH_DATA;
                default:   st_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, kind: PK_HSK, cnt: '0};
        else        st_q <= st_d;
    end

    assign phase_o = st_q.ph;
    assign kind_o  = st_q.kind;

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph <= PH_DATA); // R1
    AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph == PH_IDLE && sync_end_i && !eop_i |=> st_q.ph == PH_PID); // R2
    AST_DELAY_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph == PH_DLY1 && !eop_i |=> st_q.ph == PH_DLY2); // R3
    AST_EOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eop_i |=> st_q.ph == PH_IDLE); // R9
endmodule

// File: rtl/usbpt_fields.sv
module usbpt_fields
    import usbpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  phase_e             phase_i,
    input  pkind_e             kind_i,
    input  logic               byte_vld_i,
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic               eop_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [EP_W-1:0]    endp_o,
    output logic [FRAME_W-1:0] frame_o
);
    typedef struct packed {
        logic [BYTE_W-1:0]  lo;
        logic [HI_W-1:0]    hi;
        logic [ADDR_W-1:0]  addr;
        logic [EP_W-1:0]    endp;
        logic [FRAME_W-1:0] frame;
    } fld_t;

    fld_t f_d, f_q;
    logic take_byte;
    logic unused_crc_bits;

    assign take_byte       = byte_vld_i && !eop_i;
    assign unused_crc_bits = ^byte_i[BYTE_W-1:HI_W];

    always_comb begin
        f_d = f_q;
        if (take_byte && phase_i == PH_FLD_LO) f_d.lo = byte_i;
        if (take_byte && phase_i == PH_FLD_HI) f_d.hi = byte_i[HI_W-1:0];
        if (eop_i && phase_i == PH_CRC) begin
            if (kind_i == PK_TOK) begin
                f_d.addr = f_q.lo[ADDR_W-1:0];
                f_d.endp = {f_q.hi, f_q.lo[BYTE_W-1]};
            end else if (kind_i == PK_SOF) begin
                f_d.frame = {f_q.hi, f_q.lo};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign addr_o  = f_q.addr;
    assign endp_o  = f_q.endp;
    assign frame_o = f_q.frame;

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(eop_i && phase_i == PH_CRC && kind_i == PK_SOF) |=> $stable(frame_o)); // R8
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(eop_i && phase_i == PH_CRC && kind_i == PK_TOK) |=> $stable(addr_o) && $stable(endp_o)); // R5
endmodule

// File: rtl/usbpt_tail.sv
module usbpt_tail
    import usbpt_pkg::*;
#(
    parameter int TAIL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              eop_i,
    output logic [BYTE_W-1:0] pay_o,
    output logic              pay_vld_o
);
    typedef struct packed {
        logic [TAIL-1:0][BYTE_W-1:0] sr;
        logic [BYTE_W-1:0]           pay;
        logic                        vld;
    } tail_t;

    tail_t t_d, t_q;
    logic  shift_en;

    assign shift_en = byte_vld_i && !eop_i &&
                      (phase_i == PH_PRE || phase_i == PH_DATA);

    always_comb begin
        t_d     = t_q;
        t_d.vld = 1'b0;
        if (shift_en) begin
            t_d.sr[0] = byte_i;
            for (int i = 1; i < TAIL; i++) t_d.sr[i] = t_q.sr[i-1];
            if (phase_i == PH_DATA) begin
                t_d.pay = t_q.sr[TAIL-1];
                t_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pay_o     = t_q.pay;
    assign pay_vld_o = t_q.vld;

    AST_PAYLOAD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_i == PH_DATA && byte_vld_i && !eop_i |=> pay_vld_o); // R6
    AST_NO_STRAY_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        phase_i != PH_DATA |=> !pay_vld_o); // R6
endmodule

// File: rtl/usb_phase_tracker.sv
module usb_phase_tracker
    import usbpt_pkg::*;
#(
    parameter int TAIL = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_end_i,
    input  logic         byte_vld_i,
    input  logic [7:0]   byte_i,
    input  logic [1:0]   pid_kind_i,
    input  logic         eop_i,
    output logic [3:0]   phase_o,
    output logic [6:0]   addr_o,
    output logic [3:0]   endp_o,
    output logic [10:0]  frame_o,
    output logic [7:0]   payload_o,
    output logic         payload_vld_o
);
    phase_e phase_w;
    pkind_e kind_w;

    usbpt_seq #(.TAIL(TAIL)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_end_i (sync_end_i),
        .byte_vld_i (byte_vld_i),
        .kind_i     (pkind_e'(pid_kind_i)),
        .eop_i      (eop_i),
        .phase_o    (phase_w),
        .kind_o     (kind_w)
    );

    usbpt_fields u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase_w),
        .kind_i     (kind_w),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .eop_i      (eop_i),
        .addr_o     (addr_o),
        .endp_o     (endp_o),
        .frame_o    (frame_o)
    );

    usbpt_tail #(.TAIL(TAIL)) u_tail (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase_w),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .eop_i      (eop_i),
        .pay_o      (payload_o),
        .pay_vld_o  (payload_vld_o)
    );

    assign phase_o = phase_w;

    AST_HANDSHAKE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 4'h1 && byte_vld_i && pid_kind_i == 2'd0 && !eop_i |=> phase_o == 4'h1); // R7
endmodule

// File: tb/usb_phase_tracker_tb.sv
`timescale 1ns/1ps
module usb_phase_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_end_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [1:0]  pid_kind_i = '0;
    logic        eop_i = 1'b0;
    logic [3:0]  phase_o;
    logic [6:0]  addr_o;
    logic [3:0]  endp_o;
    logic [10:0] frame_o;
    logic [7:0]  payload_o;
    logic        payload_vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    usb_phase_tracker u_dut (.*);

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops expected payload as the design releases it
    always @(negedge clk) begin
        if (rst_n && payload_vld_o) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected payload", payload_o, -1);
            end else begin
                chk("R6 payload", payload_o, exp_q.pop_front());
                chk("R6 phase during payload", phase_o, 4'h8);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic sync_pulse();
        sync_end_i = 1; @(negedge clk); sync_end_i = 0;
    endtask
    task automatic eop_pulse();
        eop_i = 1; @(negedge clk); eop_i = 0;
    endtask
    task automatic send(logic [7:0] b, logic [1:0] k = 2'd0);
        byte_vld_i = 1; byte_i = b; pid_kind_i = k;
        @(negedge clk);
        byte_vld_i = 0;
    endtask
    task automatic pid_and_delays(logic [1:0] k);
        sync_pulse();
        send(8'hC3, k);
        idle(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 phase", phase_o, 0);
        chk("R10 addr", addr_o, 0);
        chk("R10 endp", endp_o, 0);
        chk("R10 frame", frame_o, 0);
        chk("R10 payload_vld", payload_vld_o, 0);
        rst_n = 1;
        idle(2);

        // R2: sync ignored? first: sync in idle starts PID
        sync_pulse();
        chk("R2 idle->PID", phase_o, 4'h1);
        sync_pulse();
        chk("R2 sync ignored in PID", phase_o, 4'h1);
        // R3 token path: PID byte then two delays
        send(8'h2D, 2'd1);
        chk("R3 delay1", phase_o, 4'h2);
        idle(1);
        chk("R3 delay2", phase_o, 4'h3);
        idle(1);
        chk("R3 low field (R1 code)", phase_o, 4'h4);
        // R4: addr 0x2A, endp 0xB -> bytes 0xAA, 0xFD
        send(8'hAA);
        chk("R4 high field", phase_o, 4'h5);
        chk("R4 addr not yet", addr_o, 0);
        send(8'hFD);
        chk("R4 crc phase", phase_o, 4'h6);
        eop_pulse();
        chk("R9 eop idle", phase_o, 0);
        chk("R4 addr", addr_o, 7'h2A);
        chk("R4 endp", endp_o, 4'hB);

        // R6 data packet with four payload bytes and two CRC bytes
        pid_and_delays(2'd3);
        chk("R3 pre-data", phase_o, 4'h7);
        exp_q.push_back(8'h11); exp_q.push_back(8'h22);
        exp_q.push_back(8'h33); exp_q.push_back(8'h44);
        send(8'h11);
        chk("R6 still pre-data", phase_o, 4'h7);
        send(8'h22);
        chk("R6 data phase", phase_o, 4'h8);
        send(8'h33); send(8'h44); send(8'hE1); send(8'hE2);
        eop_pulse();
        idle(2);
        chk("R6 all payload released", exp_q.size(), 0);
        chk("R5 addr held after data", addr_o, 7'h2A);
        chk("R5 endp held after data", endp_o, 4'hB);

        // R6 zero-length data: only CRC bytes, nothing released
        pid_and_delays(2'd3);
        send(8'h00); send(8'h00);
        eop_pulse();
        idle(2);

        // R8 SOF frame 0x5A3: bytes 0xA3, 0x4D
        pid_and_delays(2'd2);
        chk("R3 SOF low field", phase_o, 4'h4);
        send(8'hA3); send(8'h4D);
        chk("R8 frame before eop", frame_o, 0);
        eop_pulse();
        chk("R8 frame", frame_o, 11'h5A3);
        chk("R5 addr held after SOF", addr_o, 7'h2A);

        // R7 handshake
        sync_pulse();
        send(8'hD2, 2'd0);
        chk("R7 handshake stays PID", phase_o, 4'h1);
        idle(1);
        chk("R7 handshake still PID", phase_o, 4'h1);
        eop_pulse();
        chk("R7 idle at eop", phase_o, 0);

        // R9 truncated token
        pid_and_delays(2'd1);
        send(8'h05);
        eop_pulse();
        chk("R9 idle after truncation", phase_o, 0);
        chk("R9 addr kept", addr_o, 7'h2A);
        chk("R9 endp kept", endp_o, 4'hB);

        // R9 eop in data drops held bytes; byte with eop dropped
        pid_and_delays(2'd3);
        send(8'h77); send(8'h88);
        byte_vld_i = 1; byte_i = 8'h99; eop_i = 1;
        @(negedge clk);
        byte_vld_i = 0; eop_i = 0;
        chk("R9 eop wins over byte", phase_o, 0);
        chk("R9 no payload on eop", payload_vld_o, 0);
        exp_q.push_back(8'h5A);
        pid_and_delays(2'd3);
        send(8'h5A); send(8'hC1); send(8'hC2);
        eop_pulse();
        idle(2);
        chk("R9 only new payload", exp_q.size(), 0);
        chk("R8 frame unchanged", frame_o, 11'h5A3);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule